// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block emulates a small three-wire serial EEPROM holding 128 words of 16 bits, placed behind a byte-wide processor bus. Software drives the EEPROM's chip select, clock and data input by writing one pin register, and reads the data output back from the same register. The emulator detects edges by comparing each register write with the value held from the previous write. It decodes a start bit, a two-bit opcode and a seven-bit word address. It then performs read, write, erase, write-all, erase-all, write-enable and write-disable on its internal word storage.

The pin register answers only after two separate enable writes have been made. While either enable is missing, reads return 0xFF and pin-register writes have no effect. Stores and erases also need a write-enable flag. This flag is set and cleared only by serial commands, and reset clears it.

Top module: `serial_eeprom_emu`

## Requirements
- R1: Enable A is set by writing 0x0A and cleared by writing any other value anywhere in region 0 (bus address bits 15:13 = 0). Enable B is set by writing 0x40 and cleared by any other value in region 2. While either enable is clear, every read returns 0xFF and pin-register writes leave the register unchanged.
- R2: The pin register sits in region 5 at any address with bits 7:4 = 8 (for example 0xA080). Its bit fields are: bit 7 chip select, bit 6 clock, bit 1 data in, bit 0 data out. The other bits read back as last written. It resets to 0x01. Other offsets in region 5 read 0xFF, and writes there are ignored.
- R3: Data out reads 1 whenever the emulator is not driving it. A write that lowers the clock while chip select stays high keeps the previous data-out value.
- R4: A rising edge of chip select returns the serial engine to idle and aborts any command in progress. If the same write also raises the clock with data in = 1, that edge counts as a new start bit.
- R5: In idle, a rising clock edge with data in = 1 is the start bit. The next 10 rising edges shift in a command, MSB first. Bits 9:8 are the opcode and bits 6:0 are the word address. The command takes effect on the 10th edge.
- R6: Opcode 10 (read) drives data out to 0 on the 10th edge as a dummy bit. The next 16 rising edges present the addressed word MSB first, and the engine then returns to idle.
- R7: Opcode 01 (write) shifts in 16 data bits, MSB first, and stores them on the 16th edge, but only while the write-enable flag is set.
- R8: Opcode 11 (erase) sets the addressed word to 0xFFFF on the 10th edge, but only while the write-enable flag is set.
- R9: Opcode 00 uses command bits 7:6 to select the action: 11 sets the write-enable flag, 00 clears it, 01 writes 16 following data bits into every word, and 10 sets every word to 0xFFFF. Write-all and erase-all need the write-enable flag.
- R10: At reset the write-enable flag is clear and every word holds 0xFFFF. While the flag is clear, write, erase, write-all and erase-all leave storage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | One-cycle bus write strobe |
| busAddr | input | 16 | Bus address for reads and writes |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data, combinational from busAddr |

## Verification
A single pin-register write can cause a chip-select rising edge and a clock rising edge at the same time. The chip-select edge must reset the engine first, and the clock edge must then be seen from idle. The bench stops a read after part of its data bits have been shifted out. It then writes chip select and clock high together with data in = 1, which forms a start bit, follows with a read command to a different address, and requires the new word to come out bit for bit. The same sweep also checks that an aborted write leaves its target word unchanged.

// File: rtl/seep_pkg.sv
package seep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WRITE,
    ST_WRALL,
    ST_SHOUT
  } seqState_t;

  typedef struct packed {
    logic clearSr;
    logic shiftIn;
    logic shiftOut;
    logic loadWord;
    logic storeOne;
    logic storeAll;
    logic fillOnes;
  } dpStrobe_t;

endpackage

// File: rtl/seep_ctrl.sv
module seep_ctrl
  import seep_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7,
  parameter int BUS_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic [WORD_W-1:0] srCur,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [7:0]        pinByte,
  output logic              accessOk,
  output seqState_t         seqState,
  output logic [$clog2(((WORD_W > ADDR_W + 3) ? WORD_W : ADDR_W + 3) + 1)-1:0] bitCnt,
  output logic              writable
);

  localparam int CMD_BITS = ADDR_W + 3;
  localparam int CNT_MAX  = (WORD_W > CMD_BITS) ? WORD_W : CMD_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [2:0] REGION_ENA  = 3'd0;
  localparam logic [2:0] REGION_ENB  = 3'd2;
  localparam logic [2:0] REGION_PINS = 3'd5;
  localparam logic [3:0] PIN_SEL     = 4'h8;

  logic enA, enB;
  logic [2:0] region;
  logic pinHit;
  logic newCs, newClk, newDi, clkRise;
  logic [CMD_BITS-1:0] cmdBits;
  logic [1:0] opcode, extSel;
  seqState_t stA, stNext;
  logic [CNT_W-1:0] cntNext, cntInc;
  logic [ADDR_W-1:0] addrReg, addrNext;
  logic wenNext, doNext;
  logic [7:0] pinNext;

  assign region   = busAddr[BUS_AW-1 -: 3];
  assign accessOk = enA && enB;
  assign pinHit   = busWrite && (region == REGION_PINS) &&
                    (busAddr[7:4] == PIN_SEL) && accessOk;
  assign newCs    = busWdata[7];
  assign newClk   = busWdata[6];
  assign newDi    = busWdata[1];
  assign clkRise  = !pinByte[6] && newClk;
  assign cmdBits  = {srCur[CMD_BITS-2:0], newDi};
  assign opcode   = cmdBits[CMD_BITS-1 -: 2];
  assign extSel   = cmdBits[CMD_BITS-3 -: 2];
  assign wordAddr = addrNext;

  always_comb begin
    stNext   = seqState;
    cntNext  = bitCnt;
    addrNext = addrReg;
    wenNext  = writable;
    strobe   = '0;
    doNext   = 1'b1;
    pinNext  = pinByte;
    stA      = seqState;
    cntInc   = bitCnt;
    if (pinHit) begin
      stA    = (!pinByte[7] && newCs) ? ST_IDLE : seqState;
      stNext = stA;
      if (clkRise) begin
        if (stA == ST_CMD || stA == ST_WRITE || stA == ST_WRALL) begin
          strobe.shiftIn = 1'b1;
          cntInc = bitCnt + 1'b1;
        end
        case (stA)
          ST_IDLE: begin
            if (newDi) begin
              stNext = ST_CMD;
              cntNext = '0;
              strobe.clearSr = 1'b1;
            end
          end
          ST_CMD: begin
            cntNext = cntInc;
            if (cntInc == CNT_W'(CMD_BITS)) begin
              cntNext  = '0;
              addrNext = cmdBits[ADDR_W-1:0];
              stNext   = ST_IDLE;
              case (opcode)
                2'b01: stNext = ST_WRITE;
                2'b10: begin
                  strobe.loadWord = 1'b1;
                  cntNext = CNT_W'(WORD_W);
                  stNext = ST_SHOUT;
                  doNext = 1'b0;
                end
                2'b11: begin
                  strobe.storeOne = writable;
                  strobe.fillOnes = 1'b1;
                end
                default: begin
                  case (extSel)
                    2'b11: wenNext = 1'b1;
                    2'b00: wenNext = 1'b0;
                    2'b01: stNext = ST_WRALL;
                    default: begin
                      strobe.storeAll = writable;
                      strobe.fillOnes = 1'b1;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_WRITE, ST_WRALL: begin
            cntNext = cntInc;
            if (cntInc == CNT_W'(WORD_W)) begin
              if (stA == ST_WRITE) strobe.storeOne = writable;
              else                 strobe.storeAll = writable;
              stNext = ST_IDLE;
            end
          end
          ST_SHOUT: begin
            doNext = srCur[WORD_W-1];
            strobe.shiftOut = 1'b1;
            cntNext = bitCnt - 1'b1;
            if (bitCnt == CNT_W'(1)) stNext = ST_IDLE;
          end
          default: stNext = ST_IDLE;
        endcase
      end else if (newCs && pinByte[6] && !newClk) begin
        doNext = pinByte[0];
      end
      pinNext = {busWdata[7:1], doNext};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enA      <= 1'b0;
      enB      <= 1'b0;
      seqState <= ST_IDLE;
      bitCnt   <= '0;
      addrReg  <= '0;
      writable <= 1'b0;
      pinByte  <= 8'h01;
    end else begin
      if (busWrite && region == REGION_ENA) enA <= (busWdata == 8'h0A);
      if (busWrite && region == REGION_ENB) enB <= (busWdata == 8'h40);
      seqState <= stNext;
      bitCnt   <= cntNext;
      addrReg  <= addrNext;
      writable <= wenNext;
      pinByte  <= pinNext;
    end
  end

endmodule

// File: rtl/seep_datapath.sv
module seep_datapath
  import seep_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              shiftBit,
  output logic [WORD_W-1:0] srCur
);

  localparam int WORDS = 1 << ADDR_W;

  logic [WORD_W-1:0] words [WORDS];
  logic [WORD_W-1:0] storeData;
  logic [WORDS-1:0]  wordHit;

  assign storeData = strobe.fillOnes ? {WORD_W{1'b1}} : {srCur[WORD_W-2:0], shiftBit};

  genvar gi;
  generate
    for (gi = 0; gi < WORDS; gi++) begin : g_hit
      assign wordHit[gi] = strobe.storeAll ||
                           (strobe.storeOne && (wordAddr == ADDR_W'(gi)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) words[i] <= {WORD_W{1'b1}};
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (wordHit[i]) words[i] <= storeData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                srCur <= '0;
    else if (strobe.clearSr)  srCur <= '0;
    else if (strobe.loadWord) srCur <= words[wordAddr];
    else if (strobe.shiftIn)  srCur <= {srCur[WORD_W-2:0], shiftBit};
    else if (strobe.shiftOut) srCur <= {srCur[WORD_W-2:0], 1'b0};
  end

endmodule

// File: rtl/serial_eeprom_emu.sv
module serial_eeprom_emu
  import seep_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrite,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata
);

  localparam int CMD_BITS = ADDR_W + 3;
  localparam int CNT_W = $clog2(((WORD_W > CMD_BITS) ? WORD_W : CMD_BITS) + 1);

  dpStrobe_t strobe;
  logic [ADDR_W-1:0] wordAddr;
  logic [WORD_W-1:0] srCur;
  logic [7:0] pinByte;
  logic accessOk;
  seqState_t seqState;
  logic [CNT_W-1:0] bitCnt;
  logic writable;

  seep_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .BUS_AW(16)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .srCur(srCur), .strobe(strobe), .wordAddr(wordAddr),
    .pinByte(pinByte), .accessOk(accessOk), .seqState(seqState),
    .bitCnt(bitCnt), .writable(writable)
  );

  seep_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordAddr(wordAddr),
    .shiftBit(busWdata[1]), .srCur(srCur)
  );

  assign busRdata = (accessOk && busAddr[15:13] == 3'd5 && busAddr[7:4] == 4'h8)
                    ? pinByte : 8'hFF;

endmodule

// File: rtl/serial_eeprom_emu_checker.sv
module serial_eeprom_emu_checker
  import seep_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrite,
  input logic [15:0]      busAddr,
  input logic [7:0]       busWdata,
  input logic [7:0]       busRdata,
  input logic [7:0]       pinByte,
  input logic             accessOk,
  input seqState_t        seqState,
  input logic [CNT_W-1:0] bitCnt,
  input logic             writable
);

  localparam int CMD_BITS = ADDR_W + 3;

  assert_gate_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    !accessOk |-> busRdata == 8'hFF);

  assert_gate_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr[15:13] == 3'd5 && !accessOk) |=> $stable(pinByte));

  assert_dout_float_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_CMD || seqState == ST_WRITE || seqState == ST_WRALL) |-> pinByte[0]);

  assert_cs_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && accessOk && busAddr[15:13] == 3'd5 && busAddr[7:4] == 4'h8 &&
     !pinByte[7] && busWdata[7] && !busWdata[6]) |=> seqState == ST_IDLE);

  assert_cmd_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_CMD |-> bitCnt < CNT_W'(CMD_BITS));

  assert_shout_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_SHOUT |-> (bitCnt >= CNT_W'(1) && bitCnt <= CNT_W'(WORD_W)));

  assert_wen_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writable) |-> $past(seqState) == ST_CMD);

endmodule

bind serial_eeprom_emu serial_eeprom_emu_checker #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_checker (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .pinByte(pinByte),
  .accessOk(accessOk), .seqState(seqState), .bitCnt(bitCnt), .writable(writable)
);

// File: tb/serial_eeprom_emu_bench.sv
`timescale 1ns/1ps
module serial_eeprom_emu_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] model [128];

  localparam logic [15:0] PIN_ADDR = 16'hA080;

  always #2.5 clk = ~clk;

  serial_eeprom_emu u_serial_eeprom_emu (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0131) ^ 16'hA55A);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic pin(input bit cs, input bit ck, input bit di);
    wr(PIN_ADDR, {cs, ck, 4'b0000, di, 1'b0});
  endtask

  task automatic sendBit(input bit b);
    pin(1, 0, b);
    pin(1, 1, b);
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic frame();
    pin(0, 0, 0);
    pin(1, 0, 0);
    sendBit(1'b1);
  endtask

  task automatic opAddr(input logic [1:0] op, input int a);
    frame();
    sendBits({6'b0, op, 1'b0, 7'(a)}, 10);
  endtask

  task automatic opExt(input logic [1:0] ext);
    frame();
    sendBits({6'b0, 2'b00, ext, 6'b0}, 10);
  endtask

  task automatic readRest(output logic [15:0] w);
    logic [7:0] v;
    rd(PIN_ADDR, v);
    chk("R6 dummy bit", {15'b0, v[0]}, 16'h0000);
    for (int i = 15; i >= 0; i--) begin
      sendBit(1'b0);
      rd(PIN_ADDR, v);
      w[i] = v[0];
    end
    pin(0, 0, 0);
  endtask

  task automatic readWord(input int a, output logic [15:0] w);
    opAddr(2'b10, a);
    readRest(w);
  endtask

  task automatic writeWord(input int a, input logic [15:0] d);
    opAddr(2'b01, a);
    sendBits(d, 16);
    pin(0, 0, 0);
  endtask

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 gating
    rd(PIN_ADDR, v);
    chk("R1 read with no enable", {8'h00, v}, 16'h00FF);
    wr(16'h0000, 8'h0A);
    rd(PIN_ADDR, v);
    chk("R1 read with only enable A", {8'h00, v}, 16'h00FF);
    wr(PIN_ADDR, 8'hC6);
    wr(16'h4000, 8'h40);
    rd(PIN_ADDR, v);
    chk("R2 reset value, R1 gated write ignored", {8'h00, v}, 16'h0001);
    wr(16'h4000, 8'h41);
    rd(PIN_ADDR, v);
    chk("R1 enable B cleared", {8'h00, v}, 16'h00FF);
    wr(16'h4000, 8'h40);
    wr(16'h1FFF, 8'h0B);
    rd(PIN_ADDR, v);
    chk("R1 enable A cleared", {8'h00, v}, 16'h00FF);
    wr(16'h0000, 8'h0A);

    // R2 layout
    wr(PIN_ADDR, 8'h3C);
    rd(PIN_ADDR, v);
    chk("R2 spare bits read back, R3 data out high", {8'h00, v}, 16'h003D);
    wr(16'hA010, 8'hFF);
    rd(16'hA000, v);
    chk("R2 other offset reads FF", {8'h00, v}, 16'h00FF);
    rd(PIN_ADDR, v);
    chk("R2 other offset write ignored", {8'h00, v}, 16'h003D);
    pin(0, 0, 0);

    // R10 reset storage and gated write
    for (int a = 0; a < 128; a++) begin
      readWord(a, w);
      chk("R10 word reset to FFFF", w, 16'hFFFF);
    end
    writeWord(5, 16'h1234);
    readWord(5, w);
    chk("R10 write while disabled", w, 16'hFFFF);

    // R9 enable, R7 writes sweep
    opExt(2'b11);
    pin(0, 0, 0);
    for (int a = 0; a < 128; a++) begin
      writeWord(a, pat(a));
      model[a] = pat(a);
    end
    for (int a = 0; a < 128; a++) begin
      readWord(a, w);
      chk("R7 write then read", w, model[a]);
    end

    // R8 erase
    opAddr(2'b11, 0);  pin(0, 0, 0); model[0] = 16'hFFFF;
    opAddr(2'b11, 127); pin(0, 0, 0); model[127] = 16'hFFFF;
    for (int a = 0; a < 2; a++) begin
      readWord(a, w);
      chk("R8 erase target and neighbour", w, model[a]);
    end
    readWord(127, w);
    chk("R8 erase top word", w, model[127]);

    // R3 hold on falling edge during a read of word 1
    opAddr(2'b10, 1);
    rd(PIN_ADDR, v);
    chk("R6 dummy bit", {15'b0, v[0]}, 16'h0000);
    for (int i = 15; i >= 0; i--) begin
      pin(1, 0, 0);
      rd(PIN_ADDR, v);
      chk("R3 fall holds data out", {15'b0, v[0]}, {15'b0, (i == 15) ? 1'b0 : model[1][i + 1]});
      pin(1, 1, 0);
      rd(PIN_ADDR, v);
      chk("R6 data bit", {15'b0, v[0]}, {15'b0, model[1][i]});
    end
    pin(0, 0, 0);
    rd(PIN_ADDR, v);
    chk("R3 data out floats high", {15'b0, v[0]}, 16'h0001);

    // R4 abort of a write
    opAddr(2'b01, 2);
    sendBits(16'h00F0, 8);
    pin(0, 0, 0);
    pin(1, 0, 0);
    sendBits(16'h00FF, 8);
    pin(0, 0, 0);
    readWord(2, w);
    chk("R4 aborted write leaves word", w, model[2]);

    // R4 chip select and clock rise in one write, mid read
    opAddr(2'b10, 10);
    for (int i = 0; i < 6; i++) sendBit(1'b0);
    pin(0, 0, 0);
    pin(1, 1, 1);
    sendBits({6'b0, 2'b10, 1'b0, 7'd11}, 10);
    readRest(w);
    chk("R4 start bit on chip select rise", w, model[11]);

    // R9 write-all and erase-all
    opExt(2'b01);
    sendBits(16'h5AC3, 16);
    pin(0, 0, 0);
    for (int i = 0; i < 128; i++) model[i] = 16'h5AC3;
    for (int a = 0; a < 128; a += 9) begin
      readWord(a, w);
      chk("R9 write-all", w, model[a]);
    end
    opExt(2'b10);
    pin(0, 0, 0);
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    for (int a = 3; a < 128; a += 11) begin
      readWord(a, w);
      chk("R9 erase-all", w, model[a]);
    end

    // R9 disable, R10 gated write/erase/write-all/erase-all
    writeWord(4, 16'h0F0F);
    model[4] = 16'h0F0F;
    opExt(2'b00);
    pin(0, 0, 0);
    writeWord(6, 16'h0000);
    opAddr(2'b11, 4); pin(0, 0, 0);
    opExt(2'b10); pin(0, 0, 0);
    opExt(2'b01); sendBits(16'h0000, 16); pin(0, 0, 0);
    readWord(4, w);
    chk("R10 erase ops while disabled", w, model[4]);
    readWord(6, w);
    chk("R10 write while disabled after disable", w, model[6]);
    readWord(7, w);
    chk("R10 write-all while disabled", w, model[7]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule